// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Model

This block is a clocked, synthesizable model of a synchronous static RAM that never needs an idle bus cycle between a read and a write. Address, chip selects, write enable and byte enables are captured on the rising clock edge. The data for a write arrives the same number of cycles after its command as read data leaves after a read command. A controller can therefore issue any mix of reads and writes on consecutive cycles, and the shared data bus never has two drivers at once. The bidirectional bus is split into `din`, `dout` and an output-enable `dq_oe`, which a pad ring or testbench combines into a tristate bus.

Two latencies are available, chosen by a mode pin that is held static during traffic. In the registered mode, read data passes through an output register and write data is taken two edges after its command. In the flow-through mode, read data appears right after the address edge and write data is taken one edge after its command. A four-beat burst generator can step the two low address bits in linear or in interleaved order. The block also has a stall input that freezes every register, three chip selects, per-byte write masks, an asynchronous output disable and a sleep input that puts the outputs in high-Z.

Top module: `latewr_sram`

## Requirements
- R1: A load cycle (`burst_cont`=0, `stall`=0) with `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 starts a read at `addr` when `we_n`=1, or a write when `we_n`=0. A load cycle with any select inactive is a deselect, and it leads to no output drive.
- R2: With `flow_mode`=0, data for a read loaded at active edge k is driven on `dout` with `dq_oe`=1 from edge k+1 until edge k+2. `dq_oe` stays 0 between edges k and k+1.
- R3: With `flow_mode`=1, data for a read loaded at active edge k is driven with `dq_oe`=1 from edge k until edge k+1.
- R4: Write data on `din` is stored at active edge k+2 (`flow_mode`=0) or at edge k+1 (`flow_mode`=1) after a write command at edge k. `byte_wr_n[i]`=0 enables bits [9i+8:9i]. When all bits of `byte_wr_n` are 1, the write is aborted and memory does not change.
- R5: A cycle with `burst_cont`=1 repeats the previous operation type (read, write or deselect) at the next burst address. The burst covers the loaded address and three more, and the fifth beat returns to the loaded address.
- R6: Burst address bits [1:0] follow start+n modulo 4 when `ilv_order`=0, or start XOR n when `ilv_order`=1. All upper address bits keep their loaded value.
- R7: With `stall`=1, no state changes at the edge. `dout` and `dq_oe` keep their values, so a registered read stays driven and a pending write stays undriven.
- R8: `dq_oe` is 0 in any cycle whose edge takes write data. `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock.
- R9: `sleep` seen high at edge j makes the block sleep from edge j+1 on. While asleep, `dq_oe`=0, every other input is ignored and memory is kept. After `sleep` is seen low at edge m, edges m and m+1 are ignored and edge m+2 is processed normally.
- R10: In registered mode, a read loaded one edge after a write to the same address returns the enabled bytes of the new write data merged with the old contents of the other bytes.
- R11: During and after reset, `dq_oe` is 0, the pipeline is idle and the burst state counts as deselect, so a `burst_cont`=1 cycle right after reset drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freeze all state for this edge, active high |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command, active low |
| burst_cont | input | 1 | 1 = continue burst, 0 = load new address |
| byte_wr_n | input | NB | Per-byte write enables, active low |
| addr | input | AW | Word address |
| flow_mode | input | 1 | 1 = flow-through latency, 0 = registered latency |
| ilv_order | input | 1 | 1 = interleaved burst order, 0 = linear |
| oe_n | input | 1 | Asynchronous output disable, active high |
| sleep | input | 1 | Sleep request, active high |
| din | input | NB*9 | Write data side of the data bus |
| dout | output | NB*9 | Read data side of the data bus |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The properties assume that `flow_mode` and `ilv_order` change only while the read and write pipeline is empty. They also assume that `sleep` is raised only after all pending operations have finished. The stimulus meets both conditions: it changes mode pins only after several unstalled deselect cycles, and it surrounds every sleep request with deselects. Inside those limits, the random traffic mixes loads, burst continues, deselects with a different select dropped each time, write aborts, stalls and output disables. Each cycle's output is compared against a reference model in the bench.

// File: rtl/latewr_sram.sv
module latewr_sram #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BYTE_W = 9,
  localparam int DW = NB * BYTE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          we_n,
  input  logic          burst_cont,
  input  logic [NB-1:0] byte_wr_n,
  input  logic [AW-1:0] addr,
  input  logic          flow_mode,
  input  logic          ilv_order,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dq_oe
);

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_t;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    slp_q;
  op_t           last_op, s1_op, s2_op, cmd_op, wr_op;
  logic [AW-1:0] base, nxt_base, cmd_addr, s1_addr, s2_addr, wr_addr;
  logic [1:0]    cnt, nxt_cnt, lsb;
  logic [NB-1:0] s1_be, s2_be, wr_be;
  logic [DW-1:0] rd_word, rd_merged, q_reg;
  logic          q_vld, asleep, en, sel;

  assign asleep   = slp_q[1];
  assign en       = !stall && !asleep;
  assign sel      = !sel_a_n && sel_b && !sel_c_n;
  assign nxt_cnt  = burst_cont ? cnt + 2'd1 : 2'd0;
  assign nxt_base = burst_cont ? base : addr;
  assign lsb      = ilv_order ? (nxt_base[1:0] ^ nxt_cnt) : (nxt_base[1:0] + nxt_cnt);
  assign cmd_addr = {nxt_base[AW-1:2], lsb};

  always_comb begin
    if (burst_cont) cmd_op = last_op;
    else if (!sel)  cmd_op = OP_IDLE;
    else if (we_n)  cmd_op = OP_RD;
    else            cmd_op = OP_WR;
  end

  assign wr_op   = flow_mode ? s1_op : s2_op;
  assign wr_addr = flow_mode ? s1_addr : s2_addr;
  assign wr_be   = flow_mode ? s1_be : s2_be;
  assign rd_word = mem[s1_addr];

  always_comb begin
    rd_merged = rd_word;
    for (int b = 0; b < NB; b++)
      if (wr_op == OP_WR && wr_be[b] && wr_addr == s1_addr)
        rd_merged[b*BYTE_W +: BYTE_W] = din[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (en && wr_op == OP_WR)
      for (int b = 0; b < NB; b++)
        if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q   <= 2'b00;
      last_op <= OP_IDLE;
      base    <= '0;
      cnt     <= 2'd0;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
      q_reg   <= '0;
      q_vld   <= 1'b0;
    end else begin
      slp_q <= {slp_q[0], sleep};
      if (en) begin
        last_op <= cmd_op;
        base    <= nxt_base;
        cnt     <= nxt_cnt;
        s1_op   <= cmd_op;
        s1_addr <= cmd_addr;
        s1_be   <= ~byte_wr_n;
        s2_op   <= s1_op;
        s2_addr <= s1_addr;
        s2_be   <= s1_be;
        q_reg   <= rd_merged;
        q_vld   <= (s1_op == OP_RD);
      end
    end
  end

  assign dq_oe = !oe_n && !asleep && (flow_mode ? (s1_op == OP_RD) : q_vld);
  assign dout  = flow_mode ? rd_word : q_reg;

  AST_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !burst_cont && sel && we_n) |=> (s1_op == OP_RD && s1_addr == $past(addr))); // R1
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !burst_cont && !sel) |=> (s1_op == OP_IDLE)); // R1
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst_cont) |=> (s1_addr[AW-1:2] == $past(base[AW-1:2]))); // R5
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(s1_op) && $stable(q_reg) && $stable(q_vld) && $stable(cnt))); // R7
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_WR) |-> !dq_oe); // R8
  AST_OE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R8
  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !dq_oe); // R9
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep, 2)); // R9

endmodule

// File: tb/sim_latewr_sram.sv
module sim_latewr_sram;
  localparam int CLK = 10;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 18;

  logic clk = 0, rst_n = 0, stall = 0, sel_a_n = 1, sel_b = 0, sel_c_n = 1;
  logic we_n = 1, burst_cont = 0, flow_mode = 0, ilv_order = 0, oe_n = 0, sleep = 0;
  logic [NB-1:0] byte_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dq_oe;

  latewr_sram #(.AW(AW), .NB(NB), .BYTE_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .we_n(we_n), .burst_cont(burst_cont), .byte_wr_n(byte_wr_n),
    .addr(addr), .flow_mode(flow_mode), .ilv_order(ilv_order), .oe_n(oe_n),
    .sleep(sleep), .din(din), .dout(dout), .dq_oe(dq_oe));

  always #(CLK/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R11";

  logic [DW-1:0] m_mem [64];
  int m_s1op, m_s2op, m_last;
  logic [AW-1:0] m_s1a, m_s2a, m_base;
  logic [NB-1:0] m_s1be, m_s2be;
  logic [DW-1:0] m_q;
  logic m_qv, m_sp0, m_sp1;
  int m_cnt;

  function automatic logic [DW-1:0] pat(int a);
    return {9'(a ^ 'h155), 9'(a)};
  endfunction

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] b, int n, logic il);
    logic [1:0] s;
    s = il ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
    return {b[AW-1:2], s};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1op = 0; m_s2op = 0; m_last = 0; m_s1a = '0; m_s2a = '0; m_base = '0;
    m_s1be = '0; m_s2be = '0; m_q = '0; m_qv = 0; m_sp0 = 0; m_sp1 = 0; m_cnt = 0;
  endtask

  task automatic model_edge();
    logic asl;
    int wop, op;
    logic [AW-1:0] wa;
    logic [NB-1:0] wbe;
    asl = m_sp1;
    m_sp1 = m_sp0;
    m_sp0 = sleep;
    if (!stall && !asl) begin
      wop = flow_mode ? m_s1op : m_s2op;
      wa  = flow_mode ? m_s1a : m_s2a;
      wbe = flow_mode ? m_s1be : m_s2be;
      if (wop == 2)
        for (int b = 0; b < NB; b++)
          if (wbe[b]) m_mem[wa][b*9 +: 9] = din[b*9 +: 9];
      m_qv = (m_s1op == 1);
      if (m_qv) m_q = m_mem[m_s1a];
      m_s2op = m_s1op; m_s2a = m_s1a; m_s2be = m_s1be;
      if (burst_cont) begin
        m_cnt = (m_cnt + 1) % 4;
        op = m_last;
      end else begin
        m_cnt = 0;
        m_base = addr;
        op = (!sel_a_n && sel_b && !sel_c_n) ? (we_n ? 1 : 2) : 0;
      end
      m_last = op;
      m_s1op = op;
      m_s1a = seq_addr(m_base, m_cnt, ilv_order);
      m_s1be = ~byte_wr_n;
    end
  endtask

  task automatic tick();
    logic exp_oe;
    logic [DW-1:0] exp_d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_oe = !oe_n && !m_sp1 && (flow_mode ? (m_s1op == 1) : m_qv);
    exp_d  = flow_mode ? m_mem[m_s1a] : m_q;
    chk(tag, 32'(dq_oe), 32'(exp_oe));
    if (exp_oe) chk(tag, 32'(dout), 32'(exp_d));
  endtask

  task automatic cmd(int k, int a, logic [NB-1:0] bw);
    stall = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; burst_cont = 0;
    we_n = 1; addr = AW'(a); byte_wr_n = bw;
    case (k)
      0: begin
        case ($urandom % 3)
          0: sel_a_n = 1;
          1: sel_b = 0;
          default: sel_c_n = 1;
        endcase
      end
      2: we_n = 0;
      3: burst_cont = 1;
      default: ;
    endcase
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin cmd(0, 0, '1); tick(); end
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd4242));
    model_reset();
    // R11: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R11", 32'(dq_oe), 0);
    end
    rst_n = 1;
    cmd(3, 0, '1); tick();
    cmd(3, 0, '1); tick();
    chk("R11", 32'(dq_oe), 0);

    // fill memory in flow-through mode (R4)
    tag = "R4";
    flow_mode = 1;
    for (int a = 0; a <= 64; a++) begin
      if (a < 64) cmd(2, a, '0); else cmd(0, 0, '1);
      din = (a > 0) ? pat(a - 1) : '0;
      tick();
    end
    idle(3);

    // R5 R6: linear burst, registered mode, with wrap on the fifth beat
    tag = "R5"; flow_mode = 0; ilv_order = 0;
    cmd(1, 6, '1); tick();
    for (int i = 0; i < 5; i++) begin
      cmd(3, 0, '1); tick();
      chk("R6", 32'(dout), 32'(pat(seq_addr(6, i, 0))));
      chk("R2", 32'(dq_oe), 1);
    end
    idle(3);

    // R3 R6: interleaved burst, flow-through mode
    flow_mode = 1; ilv_order = 1; tag = "R3";
    cmd(1, 13, '1); tick();
    chk("R3", 32'(dq_oe), 1);
    chk("R6", 32'(dout), 32'(pat(seq_addr(13, 0, 1))));
    for (int i = 1; i < 5; i++) begin
      cmd(3, 0, '1); tick();
      chk("R6", 32'(dout), 32'(pat(seq_addr(13, i, 1))));
    end
    idle(3);

    // R2 R4: registered late write, then read latency
    flow_mode = 0; ilv_order = 0; tag = "R2";
    cmd(2, 20, '0); tick();
    cmd(0, 0, '1); din = '0; tick();
    d = 18'h2abcd; cmd(0, 0, '1); din = d; tick();
    cmd(1, 20, '1); tick();
    chk("R2", 32'(dq_oe), 0);
    cmd(0, 0, '1); tick();
    chk("R2", 32'(dq_oe), 1);
    chk("R4", 32'(dout), 32'(d));
    // R4: write abort
    cmd(2, 21, 2'b11); tick();
    cmd(0, 0, '1); tick();
    cmd(0, 0, '1); din = 18'h3ffff; tick();
    cmd(1, 21, '1); tick(); cmd(0, 0, '1); tick();
    chk("R4", 32'(dout), 32'(pat(21)));
    // R4: only upper byte written
    d = 18'h1f0f0;
    cmd(2, 22, 2'b01); tick();
    cmd(0, 0, '1); tick();
    cmd(0, 0, '1); din = d; tick();
    cmd(1, 22, '1); tick(); cmd(0, 0, '1); tick();
    chk("R4", 32'(dout), 32'({d[17:9], pat(22)[8:0]}));
    idle(2);
    // R3 R4: flow-through single late write followed by read of same word
    flow_mode = 1; tag = "R3";
    cmd(2, 23, '0); tick();
    d = 18'h0c3c3; din = d; cmd(1, 23, '1); tick();
    chk("R4", 32'(dq_oe), 1);
    chk("R4", 32'(dout), 32'(d));
    idle(3);

    // R10: read right behind a partial write to the same word
    flow_mode = 0; tag = "R10";
    cmd(2, 30, 2'b10); tick();
    cmd(1, 30, '1); tick();
    d = 18'h15a5a; din = d; cmd(0, 0, '1); tick();
    chk("R10", 32'(dq_oe), 1);
    chk("R10", 32'(dout), 32'({pat(30)[17:9], d[8:0]}));
    idle(2);

    // R7: stall during a registered read and during a pending write
    tag = "R7";
    cmd(1, 31, '1); tick();
    cmd(0, 0, '1); tick();
    stall = 1; tick();
    chk("R7", 32'(dq_oe), 1);
    chk("R7", 32'(dout), 32'(pat(31)));
    tick();
    chk("R7", 32'(dq_oe), 1);
    cmd(0, 0, '1); tick();
    chk("R7", 32'(dq_oe), 0);
    cmd(2, 32, '0); tick();
    stall = 1; din = 18'h3ffff; tick();
    chk("R7", 32'(dq_oe), 0);
    cmd(0, 0, '1); din = 18'h3ffff; tick();
    d = 18'h0a0a1; cmd(0, 0, '1); din = d; tick();
    cmd(1, 32, '1); tick(); cmd(0, 0, '1); tick();
    chk("R7", 32'(dout), 32'(d));
    idle(2);

    // R8: asynchronous output disable
    tag = "R8";
    cmd(1, 33, '1); tick();
    oe_n = 1; cmd(0, 0, '1); tick();
    chk("R8", 32'(dq_oe), 0);
    oe_n = 0; #1;
    chk("R8", 32'(dq_oe), 1);
    chk("R8", 32'(dout), 32'(pat(33)));
    // R1: load with one select inactive gives no drive
    tag = "R1";
    cmd(1, 34, '1); sel_b = 0; tick();
    cmd(0, 0, '1); tick();
    chk("R1", 32'(dq_oe), 0);
    idle(2);

    // R9: sleep entry, ignored inputs, wake-up
    tag = "R9";
    sleep = 1; idle(2);
    chk("R9", 32'(dq_oe), 0);
    for (int i = 0; i < 3; i++) begin cmd(2, 40, '0); din = 18'h3ffff; tick(); end
    cmd(1, 40, '1); tick(); tick();
    chk("R9", 32'(dq_oe), 0);
    sleep = 0; idle(2);
    cmd(1, 40, '1); tick(); cmd(0, 0, '1); tick();
    chk("R9", 32'(dq_oe), 1);
    chk("R9", 32'(dout), 32'(pat(40)));
    idle(2);

    // R1 R5: constrained random traffic in both latencies
    tag = "R1";
    for (int seg = 0; seg < 4; seg++) begin
      idle(3);
      flow_mode = seg[0]; ilv_order = seg[1];
      for (int i = 0; i < 1500; i++) begin
        cmd(int'($urandom % 4), int'($urandom % 64), 2'($urandom));
        din = DW'($urandom);
        stall = ($urandom % 5 == 0);
        oe_n = ($urandom % 10 == 0);
        tick();
      end
      oe_n = 0;
    end
    idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule